// File: doc/BRIEF.md
# Critical-Conduction Boost Gate Sequencer

This block decides when the switch of a boost power stage conducts. The stage runs in critical conduction mode. Each on-period is started by one of three events: the inductor current reaching zero, a watchdog on the off-time, or, after start-up, that same watchdog giving the first kick. An on-period ends when the ramp comparator reports that the sawtooth has reached the error level, when the over-current comparator trips, or when a maximum on-time counter runs out. All comparator results arrive as raw flags. They pass through two-flop synchronizers before the logic acts on them.

The zero-current flag has hysteresis. It is armed once the sensed winding voltage rises above the upper threshold. The switch turns on when the voltage then drops below the lower threshold. For a fixed time after every gate rising edge, such a falling event is discarded, which bounds the switching frequency. A supervisor enable gates all switching, and a low control level blocks any new on-period. The ramp-reset output holds the external sawtooth at zero whenever the gate is off.

Top module: `crm_gate_seq`

## Requirements
- R1: While reset is held, gateOn is 0 and rampReset is 1.
- R2: After reset with enable high and no zero-current event, the first turn-on comes from the restart timer once the gate has been off for RESTART_NS worth of clock cycles.
- R3: A turn-on follows a zcdLoRaw assertion only if zcdHiRaw was asserted since the last lower-threshold crossing. A lower-threshold crossing that was not preceded by an upper-threshold crossing starts nothing.
- R4: A zero-current falling event that is recognized within BLANK_NS worth of cycles after a gate rising edge is discarded, and a later event still turns the gate on.
- R5: A rampHitRaw assertion ends the on-period, with gateOn falling within 4 clock cycles.
- R6: An ocpRaw assertion ends the on-period, with gateOn falling within 4 clock cycles.
- R7: When no ramp match or over-current arrives, the gate stays high for exactly MAXON_NS worth of cycles and then falls.
- R8: While compLowRaw is 1, no on-period starts, whether from a zero-current event or from the restart timer. Once it is released with the off-time already expired, the gate rises within 6 cycles.
- R9: Deasserting enable drives gateOn low at the next clock and clears the timers, so after re-enable the first turn-on again waits the full restart time.
- R10: rampReset is always the inverse of gateOn.
- R11: After an on-period with no following zero-current event, the gate stays off for RESTART_NS worth of cycles and is then forced on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Supervisor switching enable, synchronous |
| zcdHiRaw | input | 1 | Winding voltage above upper zero-current threshold |
| zcdLoRaw | input | 1 | Winding voltage below lower zero-current threshold |
| rampHitRaw | input | 1 | Sawtooth has reached the error-amplifier level |
| ocpRaw | input | 1 | Switch current above the over-current limit |
| compLowRaw | input | 1 | Error level below the zero-duty threshold |
| gateOn | output | 1 | Gate-enable to the driver |
| rampReset | output | 1 | Holds the sawtooth at zero while high |

## Verification
The bench keeps the 250 MHz clock but shortens the windows: BLANK_NS=80 (20 cycles), RESTART_NS=400 (100 cycles) and MAXON_NS=240 (60 cycles). With these values the exact restart and maximum on-time durations can be measured cycle for cycle. A ramp-terminated on-period also ends early enough that a following zero-current event still falls inside the blanking window. The compLow hold lasts longer than the restart time, so the saturated restart timer releases the gate right after compLow is deasserted.

// File: rtl/crm_pkg.sv
package crm_pkg;
  // strobes from control to timer datapath
  typedef struct packed {
    logic turnOn;    // gate rises at this edge
    logic gateHigh;  // gate currently high
    logic halt;      // switching disabled by supervisor
  } crm_strobe_t;

  function automatic int nsToCycles(input int clkMhz, input int ns);
    int c;
    c = (clkMhz * ns + 999) / 1000;
    return (c < 2) ? 2 : c;
  endfunction
endpackage

// File: rtl/crm_sync.sv
module crm_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] rawIn,
  output logic [W-1:0] syncOut
);
  logic [W-1:0] stage1;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stage1[i]  <= 1'b0;
        syncOut[i] <= 1'b0;
      end else begin
        stage1[i]  <= rawIn[i];
        syncOut[i] <= stage1[i];
      end
    end
  end
endmodule

// File: rtl/crm_timers.sv
module crm_timers
  import crm_pkg::*;
#(
  parameter int BLANK_CYC   = 825,
  parameter int RESTART_CYC = 37500,
  parameter int MAXON_CYC   = 10250
) (
  input  logic        clk,
  input  logic        rstN,
  input  crm_strobe_t strb,
  output logic        blankActive,
  output logic        restartHit,
  output logic        maxOnHit
);
  localparam int BW = $clog2(BLANK_CYC + 1);
  localparam int RW = $clog2(RESTART_CYC);
  localparam int MW = $clog2(MAXON_CYC);
  localparam logic [BW-1:0] BLANK_LOAD = BW'(BLANK_CYC);
  localparam logic [RW-1:0] OFF_LAST   = RW'(RESTART_CYC - 1);
  localparam logic [MW-1:0] ON_LAST    = MW'(MAXON_CYC - 1);

  logic [BW-1:0] blankCnt;
  logic [RW-1:0] offCnt;
  logic [MW-1:0] onCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blankCnt <= '0;
      offCnt   <= '0;
      onCnt    <= '0;
    end else begin
      if (strb.halt)             blankCnt <= '0;
      else if (strb.turnOn)      blankCnt <= BLANK_LOAD;
      else if (blankCnt != '0)   blankCnt <= blankCnt - 1'b1;

      if (strb.halt || strb.gateHigh || strb.turnOn) offCnt <= '0;
      else if (offCnt != OFF_LAST)                   offCnt <= offCnt + 1'b1;

      if (strb.halt || !strb.gateHigh) onCnt <= '0;
      else if (onCnt != ON_LAST)       onCnt <= onCnt + 1'b1;
    end
  end

  assign blankActive = (blankCnt != '0);
  assign restartHit  = !strb.halt && !strb.gateHigh && (offCnt == OFF_LAST);
  assign maxOnHit    = strb.gateHigh && (onCnt == ON_LAST);

  // R4
  blank_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.turnOn && !strb.halt |=> blankActive);
  // R11
  restart_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.gateHigh |=> !restartHit);
endmodule

// File: rtl/crm_ctrl.sv
module crm_ctrl
  import crm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        zcdHiS,
  input  logic        zcdLoS,
  input  logic        rampHitS,
  input  logic        ocpS,
  input  logic        compLowS,
  input  logic        blankActive,
  input  logic        restartHit,
  input  logic        maxOnHit,
  output crm_strobe_t strb,
  output logic        gate
);
  logic zcdArmed;
  logic zcdEvent;
  logic startReq;
  logic stopReq;
  logic gateNext;

  // hysteretic zero-current flag: set above upper, cleared below lower
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       zcdArmed <= 1'b0;
    else if (zcdLoS) zcdArmed <= 1'b0;
    else if (zcdHiS) zcdArmed <= 1'b1;
  end

  assign zcdEvent = zcdArmed && zcdLoS;
  assign startReq = !compLowS && ((zcdEvent && !blankActive) || restartHit);
  assign stopReq  = rampHitS || ocpS || maxOnHit;

  always_comb begin
    if (!enable)   gateNext = 1'b0;
    else if (gate) gateNext = !stopReq;
    else           gateNext = startReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) gate <= 1'b0;
    else       gate <= gateNext;
  end

  assign strb.turnOn   = enable && !gate && startReq;
  assign strb.gateHigh = gate;
  assign strb.halt     = !enable;

  // R6
  ocp_cut_chk: assert property (@(posedge clk) disable iff (!rstN)
    gate && ocpS |=> !gate);
  // R9
  disable_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !gate);
  // R8
  comp_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    !gate && compLowS |=> !gate);
  // R7
  max_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    maxOnHit |=> !gate);
endmodule

// File: rtl/crm_gate_seq.sv
module crm_gate_seq
  import crm_pkg::*;
#(
  parameter int CLK_MHZ    = 250,
  parameter int BLANK_NS   = 3300,
  parameter int RESTART_NS = 150000,
  parameter int MAXON_NS   = 41000
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic zcdHiRaw,
  input  logic zcdLoRaw,
  input  logic rampHitRaw,
  input  logic ocpRaw,
  input  logic compLowRaw,
  output logic gateOn,
  output logic rampReset
);
  localparam int BLANK_CYC   = nsToCycles(CLK_MHZ, BLANK_NS);
  localparam int RESTART_CYC = nsToCycles(CLK_MHZ, RESTART_NS);
  localparam int MAXON_CYC   = nsToCycles(CLK_MHZ, MAXON_NS);

  logic [4:0]  syncFlags;
  crm_strobe_t strb;
  logic        blankActive, restartHit, maxOnHit;
  logic        gate;

  crm_sync #(.W(5)) uSync (
    .clk(clk), .rstN(rstN),
    .rawIn({compLowRaw, ocpRaw, rampHitRaw, zcdLoRaw, zcdHiRaw}),
    .syncOut(syncFlags)
  );

  crm_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable),
    .zcdHiS(syncFlags[0]), .zcdLoS(syncFlags[1]), .rampHitS(syncFlags[2]),
    .ocpS(syncFlags[3]), .compLowS(syncFlags[4]),
    .blankActive(blankActive), .restartHit(restartHit), .maxOnHit(maxOnHit),
    .strb(strb), .gate(gate)
  );

  crm_timers #(
    .BLANK_CYC(BLANK_CYC), .RESTART_CYC(RESTART_CYC), .MAXON_CYC(MAXON_CYC)
  ) uTimers (
    .clk(clk), .rstN(rstN), .strb(strb),
    .blankActive(blankActive), .restartHit(restartHit), .maxOnHit(maxOnHit)
  );

  assign gateOn    = gate;
  assign rampReset = !gate;
endmodule

// File: tb/crm_gate_seq_test.sv
module crm_gate_seq_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic zcdHiRaw = 1'b0, zcdLoRaw = 1'b0, rampHitRaw = 1'b0;
  logic ocpRaw = 1'b0, compLowRaw = 1'b0;
  logic gateOn, rampReset;

  int nChecks = 0;
  int nFails = 0;
  int cycleCount = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  crm_gate_seq #(.CLK_MHZ(250), .BLANK_NS(80), .RESTART_NS(400), .MAXON_NS(240)) uut (
    .clk(clk), .rstN(rstN), .enable(enable),
    .zcdHiRaw(zcdHiRaw), .zcdLoRaw(zcdLoRaw), .rampHitRaw(rampHitRaw),
    .ocpRaw(ocpRaw), .compLowRaw(compLowRaw),
    .gateOn(gateOn), .rampReset(rampReset)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycleCount++;
    if (cycleCount > 20000 && !finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycleCount, 20000);
      summary();
    end
  end

  // wait up to lim cycles for gate to reach level lvl
  task automatic waitLevel(input bit lvl, input int lim, output bit ok, output int n);
    ok = 1'b0; n = 0;
    while (n < lim && !ok) begin
      @(negedge clk); n++;
      if (gateOn == lvl) ok = 1'b1;
    end
  endtask

  // count cycles the gate holds its present level
  task automatic holdLen(output int n);
    bit lvl;
    lvl = gateOn; n = 0;
    while (gateOn == lvl && n < 1000) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic zcdPulse();
    zcdLoRaw = 1'b0; zcdHiRaw = 1'b1;
    repeat (3) @(negedge clk);
    zcdHiRaw = 1'b0; zcdLoRaw = 1'b1;
  endtask

  task automatic testReset();
    repeat (4) @(negedge clk);
    check(gateOn == 1'b0, "R1 gate", gateOn, 0);
    check(rampReset == 1'b1, "R1 rampReset", rampReset, 1);
    rstN = 1'b1; enable = 1'b1;
  endtask

  task automatic testStartup();
    int n; bit ok;
    waitLevel(1'b1, 300, ok, n);
    check(ok && n >= 99 && n <= 101, "R2 startup delay", n, 100);
    check(rampReset == 1'b0, "R10 rampReset while on", rampReset, 0);
  endtask

  task automatic testMaxOnAndRestart();
    int n;
    holdLen(n);
    check(n == 60, "R7 max on length", n, 60);
    check(rampReset == 1'b1, "R10 rampReset while off", rampReset, 1);
    holdLen(n);
    check(n >= 99 && n <= 101, "R11 restart off time", n, 100);
  endtask

  task automatic testRamp();
    int n; bit ok;
    rampHitRaw = 1'b1;
    waitLevel(1'b0, 6, ok, n);
    rampHitRaw = 1'b0;
    check(ok && n <= 4, "R5 ramp turn-off", n, 3);
  endtask

  task automatic testBlank();
    int n; bit ok;
    repeat (25) @(negedge clk);
    zcdPulse();
    waitLevel(1'b1, 8, ok, n);
    check(ok, "R3 armed zcd turn-on", ok, 1);
    // end early, still inside blanking window
    rampHitRaw = 1'b1;
    waitLevel(1'b0, 6, ok, n);
    rampHitRaw = 1'b0;
    zcdPulse();
    waitLevel(1'b1, 8, ok, n);
    check(!ok, "R4 early zcd ignored", ok, 0);
    repeat (10) @(negedge clk);
    zcdPulse();
    waitLevel(1'b1, 8, ok, n);
    check(ok, "R4 later zcd accepted", ok, 1);
  endtask

  task automatic testUnarmed();
    int n; bit ok;
    rampHitRaw = 1'b1;
    waitLevel(1'b0, 6, ok, n);
    rampHitRaw = 1'b0;
    repeat (25) @(negedge clk);
    zcdLoRaw = 1'b0;
    repeat (3) @(negedge clk);
    zcdLoRaw = 1'b1;
    waitLevel(1'b1, 10, ok, n);
    check(!ok, "R3 unarmed low crossing", ok, 0);
    zcdPulse();
    waitLevel(1'b1, 8, ok, n);
    check(ok, "R3 armed after high crossing", ok, 1);
  endtask

  task automatic testOcp();
    int n; bit ok;
    ocpRaw = 1'b1;
    waitLevel(1'b0, 6, ok, n);
    ocpRaw = 1'b0;
    check(ok && n <= 4, "R6 ocp turn-off", n, 3);
  endtask

  task automatic testCompLow();
    int n; bit ok;
    compLowRaw = 1'b1;
    repeat (25) @(negedge clk);
    zcdPulse();
    waitLevel(1'b1, 150, ok, n);
    check(!ok, "R8 no start while comp low", ok, 0);
    compLowRaw = 1'b0;
    waitLevel(1'b1, 6, ok, n);
    check(ok, "R8 start after release", n, 3);
  endtask

  task automatic testDisable();
    int n; bit ok;
    check(gateOn == 1'b1, "R9 precondition gate on", gateOn, 1);
    enable = 1'b0;
    @(negedge clk);
    check(gateOn == 1'b0, "R9 gate low next clock", gateOn, 0);
    repeat (10) @(negedge clk);
    check(gateOn == 1'b0, "R9 gate stays low", gateOn, 0);
    enable = 1'b1;
    waitLevel(1'b1, 300, ok, n);
    check(ok && n >= 99 && n <= 101, "R9 full restart after re-enable", n, 100);
  endtask

  initial begin
    testReset();
    testStartup();
    testMaxOnAndRestart();
    testRamp();
    testBlank();
    testUnarmed();
    testOcp();
    testCompLow();
    testDisable();
    finished = 1'b1;
    summary();
  end
endmodule